// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block turns single-word requests from inside the chip into transfers on a 16-line external bus that carries both addresses and data. The address goes out in two byte-wide slices, each marked by its own latch pulse, so that external byte latches can capture it. The data phase follows on the same lines. A memory transfer runs four phases: low address (T1), high address (T2), data strobe (TW) and data hold/sample (T4). An I/O transfer has no high address slice and runs T1, TW and T4 only.

On the inside, a requester raises `req` with a word address, write data, two byte-lane enables, a write flag and an I/O flag. The controller captures these at the edge where it starts, so they may change once T1 is visible. One cycle after T4 it pulses `ack`. For a read, `rdata` holds the word sampled from the bus at the end of T4. The bus pins use separate output, output-enable and input vectors, so the pad ring can build the tri-state.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset, and whenever no transfer is running, `ale_lo`, `ale_hi`, `pio` and `ad_oe` are 0, and `we_n`, `oe_n` and `bhe_n` are 1.
- R2: A memory request that is accepted at an edge runs T1, T2, TW and T4 in the next four cycles, one cycle each. `ack` is high in the cycle after T4.
- R3: An I/O request (`req_io`=1) runs T1, TW and T4 only. `ale_hi` stays 0, `pio` is 1 from T1 through T4, and `ack` follows in the cycle after T4.
- R4: In T1, `ale_lo` is 1 and lines 7..1 carry address bits 7..1. Line 0 carries the inverse of `req_be[0]`, so it is 0 when the low byte lane takes part. Lines 15..8 are 0 and `ad_oe` is 1.
- R5: In T2, `ale_hi` is 1, lines 7..0 carry address bits 15..8, lines 15..8 are 0 and `ad_oe` is 1.
- R6: `oe_n` is 1 during T1 and T2 and 0 during TW and T4.
- R7: `we_n` is 0 only in the TW phase of a write (`req_we`=1).
- R8: A write drives the captured write data with `ad_oe`=1 through TW and T4. A read holds `ad_oe` at 0 from TW until the transfer ends.
- R9: A read loads `rdata` with `ad_in` as sampled at the final edge of T4. `rdata` then keeps that value until the next read completes, and writes leave it unchanged.
- R10: `bhe_n` is the inverse of `req_be[1]` from T1 through T4.
- R11: `ack` lasts exactly one cycle. A `req` held high during a transfer, or during its `ack` cycle, does not start another transfer. Address, data and flag changes after the start edge do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O transfer, 0 = memory transfer |
| req_addr | input | 15 | Word address, bits 15..1 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables; bit 0 = low byte, bit 1 = high byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data captured by the last read |
| ad_out | output | 16 | Multiplexed bus output value |
| ad_oe | output | 1 | Bus output enable (1 = controller drives the lines) |
| ad_in | input | 16 | Multiplexed bus input value |
| ale_lo | output | 1 | Low-address latch pulse (T1) |
| ale_hi | output | 1 | High-address latch pulse (T2) |
| we_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low data-phase enable |
| bhe_n | output | 1 | Active-low high byte enable |
| pio | output | 1 | I/O transfer indicator |

## Verification
Transfers are tried in all four combinations of read/write and memory/I/O. The stimulus uses all byte-enable values and the address extremes 0x0000 and 0xFFFE, plus seeded random addresses and data. Each combination shows whether the phase count and strobe pattern follow the flags. The bus input carries a decoy word during TW and the real word during T4, which shows whether the sample lands at the end of T4. After T1, the bench scrambles the request fields and keeps `req` high through the `ack` cycle. This shows whether the fields are captured at the start edge and whether a held request is ignored until the controller is idle again.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T4   = 3'd4
  } phase_t;

  // Phase order: T2 is present for memory transfers only.
  function automatic phase_t phase_after(phase_t cur, logic start, logic io);
    phase_t nxt;
    case (cur)
      PH_IDLE: nxt = start ? PH_T1 : PH_IDLE;
      PH_T1:   nxt = io ? PH_TW : PH_T2;
      PH_T2:   nxt = PH_TW;
      PH_TW:   nxt = PH_T4;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic is_addr_phase(phase_t p);
    return (p == PH_T1) || (p == PH_T2);
  endfunction

  function automatic logic is_data_phase(phase_t p);
    return (p == PH_TW) || (p == PH_T4);
  endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             req_io,
  input  logic [BUS_W-1:1] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [1:0]       req_be,
  input  logic             hold,
  output phase_t           phase,
  output logic             start,
  output logic [BUS_W-1:1] x_addr,
  output logic [BUS_W-1:0] x_wdata,
  output logic [1:0]       x_be,
  output logic             x_we,
  output logic             x_io
);

  assign start = (phase == PH_IDLE) && req && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      x_addr  <= '0;
      x_wdata <= '0;
      x_be    <= '0;
      x_we    <= 1'b0;
      x_io    <= 1'b0;
    end else begin
      phase <= phase_after(phase, start, x_io);
      if (start) begin
        x_addr  <= req_addr;
        x_wdata <= req_wdata;
        x_be    <= req_be;
        x_we    <= req_we;
        x_io    <= req_io;
      end
    end
  end

endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  phase_t           phase,
  input  logic [BUS_W-1:1] x_addr,
  input  logic [BUS_W-1:0] x_wdata,
  input  logic [1:0]       x_be,
  input  logic             x_we,
  input  logic             x_io,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             ale_lo,
  output logic             ale_hi,
  output logic             we_n,
  output logic             oe_n,
  output logic             bhe_n,
  output logic             pio
);

  localparam int HALF = BUS_W / 2;

  // Low slice: address bits above 0, with line 0 used as the low-byte enable.
  function automatic logic [BUS_W-1:0] low_slice(logic [BUS_W-1:1] a, logic be0);
    logic [BUS_W-1:0] v;
    v = '0;
    v[HALF-1:1] = a[HALF-1:1];
    v[0] = ~be0;
    return v;
  endfunction

  function automatic logic [BUS_W-1:0] high_slice(logic [BUS_W-1:1] a);
    logic [BUS_W-1:0] v;
    v = '0;
    v[HALF-1:0] = a[BUS_W-1:HALF];
    return v;
  endfunction

  logic busy;
  assign busy = (phase != PH_IDLE);

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    case (phase)
      PH_T1: begin
        ad_out = low_slice(x_addr, x_be[0]);
        ad_oe  = 1'b1;
      end
      PH_T2: begin
        ad_out = high_slice(x_addr);
        ad_oe  = 1'b1;
      end
      PH_TW, PH_T4: begin
        ad_out = x_we ? x_wdata : '0;
        ad_oe  = x_we;
      end
      default: ;
    endcase
  end

  assign ale_lo = (phase == PH_T1);
  assign ale_hi = (phase == PH_T2);
  assign we_n   = !((phase == PH_TW) && x_we);
  assign oe_n   = !is_data_phase(phase);
  assign bhe_n  = !(busy && x_be[1]);
  assign pio    = busy && x_io;

endmodule

// File: rtl/mbus_rcap.sv
module mbus_rcap
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic             x_we,
  input  logic [BUS_W-1:0] ad_in,
  output logic             ack,
  output logic [BUS_W-1:0] rdata
);

  logic last_phase;
  assign last_phase = (phase == PH_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= last_phase;
      if (last_phase && !x_we) rdata <= ad_in;
    end
  end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             req_io,
  input  logic [BUS_W-1:1] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [1:0]       req_be,
  output logic             ack,
  output logic [BUS_W-1:0] rdata,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_in,
  output logic             ale_lo,
  output logic             ale_hi,
  output logic             we_n,
  output logic             oe_n,
  output logic             bhe_n,
  output logic             pio
);

  phase_t           phase;
  logic             start;
  logic [BUS_W-1:1] x_addr;
  logic [BUS_W-1:0] x_wdata;
  logic [1:0]       x_be;
  logic             x_we;
  logic             x_io;

  mbus_seq #(.BUS_W(BUS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_we    (req_we),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .hold      (ack),
    .phase     (phase),
    .start     (start),
    .x_addr    (x_addr),
    .x_wdata   (x_wdata),
    .x_be      (x_be),
    .x_we      (x_we),
    .x_io      (x_io)
  );

  mbus_lanes #(.BUS_W(BUS_W)) u_lanes (
    .phase   (phase),
    .x_addr  (x_addr),
    .x_wdata (x_wdata),
    .x_be    (x_be),
    .x_we    (x_we),
    .x_io    (x_io),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale_lo  (ale_lo),
    .ale_hi  (ale_hi),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .bhe_n   (bhe_n),
    .pio     (pio)
  );

  mbus_rcap #(.BUS_W(BUS_W)) u_rcap (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .x_we  (x_we),
    .ad_in (ad_in),
    .ack   (ack),
    .rdata (rdata)
  );

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk
  import mbus_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_t phase,
  input logic   start,
  input logic   ack,
  input logic   ad_oe,
  input logic   ale_lo,
  input logic   ale_hi,
  input logic   we_n,
  input logic   oe_n,
  input logic   bhe_n,
  input logic   pio
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (!ale_lo && !ale_hi && !pio && !ad_oe && we_n && oe_n && bhe_n));

  a_r2_start_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ale_lo);

  a_r2_mem_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_lo && !pio) |=> ale_hi);

  a_r3_io_no_high_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pio |-> !ale_hi);

  a_r3_io_low_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_lo && pio) |=> !oe_n);

  a_r6_oe_high_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_lo || ale_hi) |-> oe_n);

  a_r7_we_in_driven_data: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (ad_oe && !oe_n));

  a_r7_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> we_n);

  a_r11_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r11_no_start_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !start);

endmodule

bind mbus_ctrl mbus_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .phase  (phase),
  .start  (start),
  .ack    (ack),
  .ad_oe  (ad_oe),
  .ale_lo (ale_lo),
  .ale_hi (ale_hi),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .bhe_n  (bhe_n),
  .pio    (pio)
);

// File: tb/test_mbus_ctrl.sv
`timescale 1ns/100ps
module test_mbus_ctrl;

  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic          req_io = 1'b0;
  logic [BW-1:1] req_addr = '0;
  logic [BW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          ack;
  logic [BW-1:0] rdata;
  logic [BW-1:0] ad_out;
  logic          ad_oe;
  logic [BW-1:0] ad_in = '0;
  logic          ale_lo, ale_hi, we_n, oe_n, bhe_n, pio;

  int checks = 0;
  int fails = 0;
  logic [BW-1:0] last_read = '0;

  always #2.5 clk = ~clk;

  mbus_ctrl #(.BUS_W(BW)) i_mbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_io(req_io),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ack(ack), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale_lo(ale_lo), .ale_hi(ale_hi), .we_n(we_n), .oe_n(oe_n),
    .bhe_n(bhe_n), .pio(pio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench view of the two address slices (byte address, bit 0 ignored).
  function automatic logic [15:0] t1_word(logic [15:0] byte_addr, logic [1:0] be);
    return (byte_addr % 16'd256) - (byte_addr % 16'd2) + (be[0] ? 16'd0 : 16'd1);
  endfunction

  function automatic logic [15:0] t2_word(logic [15:0] byte_addr);
    return byte_addr / 16'd256;
  endfunction

  task automatic idle_chk(input string tag);
    chk({tag, " R1 ale_lo"}, ale_lo, 0);
    chk({tag, " R1 ale_hi"}, ale_hi, 0);
    chk({tag, " R1 pio"}, pio, 0);
    chk({tag, " R1 ad_oe"}, ad_oe, 0);
    chk({tag, " R1 we_n"}, we_n, 1);
    chk({tag, " R1 oe_n"}, oe_n, 1);
    chk({tag, " R1 bhe_n"}, bhe_n, 1);
  endtask

  // Called at a falling edge; the next rising edge accepts.
  task automatic xfer(input logic [15:0] a, input logic [15:0] wd, input logic [1:0] be,
                      input logic we, input logic io, input logic [15:0] rv);
    req = 1'b1; req_addr = a[15:1]; req_wdata = wd; req_be = be; req_we = we; req_io = io;
    @(negedge clk); // T1
    chk("R4 ale_lo", ale_lo, 1);
    chk("R4 ale_hi", ale_hi, 0);
    chk("R4 bus", ad_out, t1_word(a, be));
    chk("R4 ad_oe", ad_oe, 1);
    chk("R6 oe_n T1", oe_n, 1);
    chk("R7 we_n T1", we_n, 1);
    chk("R10 bhe_n", bhe_n, !be[1]);
    chk("R3 pio T1", pio, io);
    chk("R2 ack T1", ack, 0);
    // scramble request fields; held req must not disturb the running transfer
    req_addr = $urandom; req_wdata = $urandom; req_be = $urandom;
    req_we = $urandom; req_io = $urandom;
    if (!io) begin
      @(negedge clk); // T2
      chk("R5 ale_hi", ale_hi, 1);
      chk("R5 ale_lo", ale_lo, 0);
      chk("R5 bus", ad_out, t2_word(a));
      chk("R5 ad_oe", ad_oe, 1);
      chk("R6 oe_n T2", oe_n, 1);
      chk("R2 pio T2", pio, 0);
      chk("R11 bhe_n T2", bhe_n, !be[1]);
    end
    @(negedge clk); // TW
    chk("R3 ale_hi TW", ale_hi, 0);
    chk("R2 ale_lo TW", ale_lo, 0);
    chk("R6 oe_n TW", oe_n, 0);
    chk("R7 we_n TW", we_n, !we);
    chk("R8 ad_oe TW", ad_oe, we);
    if (we) chk("R8 wdata TW", ad_out, wd);
    chk("R3 pio TW", pio, io);
    chk("R10 bhe_n TW", bhe_n, !be[1]);
    ad_in = ~rv; // decoy: must not be sampled
    @(negedge clk); // T4
    chk("R6 oe_n T4", oe_n, 0);
    chk("R7 we_n T4", we_n, 1);
    chk("R8 ad_oe T4", ad_oe, we);
    if (we) chk("R8 wdata T4", ad_out, wd);
    chk("R3 pio T4", pio, io);
    chk("R2 ack T4", ack, 0);
    ad_in = rv;
    @(negedge clk); // ack cycle
    if (!we) last_read = rv;
    chk("R2 ack", ack, 1);
    chk("R9 rdata", rdata, last_read);
    idle_chk("ack");
    ad_in = $urandom;
    @(negedge clk); // req still high: must not have started
    chk("R11 ack single", ack, 0);
    chk("R11 no restart", ale_lo, 0);
    chk("R9 rdata hold", rdata, last_read);
    req = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    idle_chk("reset");
    chk("R2 ack reset", ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("post-reset");
    // directed corners
    xfer(16'h0000, 16'hA5A5, 2'b11, 1'b1, 1'b0, 16'h0000);
    xfer(16'hFFFE, 16'h0000, 2'b01, 1'b0, 1'b0, 16'hC3E1);
    xfer(16'h1234, 16'h5A5A, 2'b10, 1'b1, 1'b1, 16'h0000);
    xfer(16'h00FE, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h7E81);
    xfer(16'hAB02, 16'hFFFF, 2'b01, 1'b1, 1'b0, 16'h1111); // write leaves rdata (R9)
    @(negedge clk);
    idle_chk("gap");
    // seeded random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      a = $urandom;
      a[0] = 1'b0;
      xfer(a, $urandom, $urandom, $urandom, $urandom, $urandom);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        idle_chk("rand gap");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule